// File: doc/BRIEF.md
# Plane Scaling Descriptor Generator

This block decides how a display plane is resized and writes the scaling part of that plane's descriptor. The block takes a source width and height, a destination width and height, a line-buffer base address and a filter-kernel offset, all sampled on a start strobe. It then picks a mode for each axis: no scaling, trapezoidal decimation or polyphase magnification. It folds the two modes into a 3-bit code and reports the control-word scaler fields.

For a plane that needs scaling, the block works out the scale factors and their reciprocals with one shared sequential divider. It then streams the descriptor words, one per cycle with a valid flag. The number of words and their order depend on the chosen modes. The block also reports how much line-buffer memory the plane needs. A unity plane (no scaling on either axis) finishes at once and emits no words. A zero destination size is refused with an error flag.

Top module: `scale_desc_gen`

## Requirements
- R1: Each axis picks its mode by comparing destination size with source size: larger selects polyphase (PPF), smaller selects trapezoidal (TPZ), equal selects none. `ctl_bits` carries a 3-bit code in bits 10:8 and the same code in bits 7:5. The codes for each horizontal/vertical pair are: PPF/PPF=0, TPZ/PPF=1, PPF/TPZ=2, TPZ/TPZ=3, PPF/none=4, none/PPF=5, none/TPZ=6, TPZ/none=7. `ctl_bits` is valid from the cycle after an accepted start.
- R2: `ctl_bits` bit 4 (unity) is 1 only when both axes are none. In that case the code is 0, no word is emitted and `busy` stays low.
- R3: The first word of a non-unity sequence is the scaled-size word: destination width in bits 11:0, destination height in bits 27:16, all other bits 0.
- R4: The next word is the line-buffer base address, taken unchanged from `lb_base`. It is emitted only when the vertical mode is not none.
- R5: A polyphase parameter word holds the scale (2^16*src)/dst, truncated to 17 bits, in bits 24:8. Bit 30 is set, and all other bits are 0, which makes the initial phase in bits 6:0 zero.
- R6: A trapezoidal axis emits two words. The first holds the scale, truncated to 21 bits, in bits 28:8, with 0 in all other bits. The second holds 0xFFFFFFFF divided by the full scale, truncated to 16 bits, in bits 15:0.
- R7: The parameter words follow in a fixed order: horizontal PPF, then vertical PPF followed by the context word 0xC0C0C0C0, then horizontal TPZ, then vertical TPZ followed by 0xC0C0C0C0. Only the words for the modes in use appear.
- R8: If either axis is polyphase, the sequence ends with four identical kernel-pointer words. Each holds `kern_ofs` in bits 13:0, with 0 in all other bits.
- R9: `lb_size` is 0 for unity. Otherwise it is max(src_w, dst_w) times 8 when the vertical mode is TPZ, and times 16 in all other cases, rounded up to a multiple of 32. It is valid from the cycle after an accepted start.
- R10: `busy` rises in the cycle after an accepted non-unity start and falls in the cycle after the last word. All words of a sequence are emitted on consecutive cycles, and `out_valid` is high only while `busy` is high.
- R11: A start with `dst_w` or `dst_h` equal to zero sets `err` in the next cycle, clears `ctl_bits` and `lb_size` to 0, and emits no words. `err` clears at the next accepted start with valid sizes.
- R12: A start that arrives while `busy` is high is ignored: the running sequence, `err`, `ctl_bits` and `lb_size` are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start strobe; samples all size and address inputs |
| src_w | input | DIM_W | Source width in pixels |
| src_h | input | DIM_W | Source height in lines |
| dst_w | input | DIM_W | Destination width in pixels |
| dst_h | input | DIM_W | Destination height in lines |
| lb_base | input | 32 | Line-buffer base address placed in the descriptor |
| kern_ofs | input | KOFS_W | Filter kernel offset placed in the pointer words |
| busy | output | 1 | Divisions or emission in progress |
| err | output | 1 | Last accepted start had a zero destination size |
| ctl_bits | output | 11 | Control-word scaler fields (unity bit 4, codes 7:5 and 10:8) |
| lb_size | output | DIM_W+5 | Line-buffer bytes required |
| out_valid | output | 1 | `out_word` holds a descriptor word |
| out_word | output | 32 | Descriptor word |

## Verification
If the latched mode pair is wrong, the effect shows in `ctl_bits` one cycle after the start. The sequence shape is also wrong: the base word, the context words and the kernel pointers appear or are missing in the first word positions. If a divider result is wrong, the effect shows only later, in the parameter words. These come after 132 cycles of division, so the scoreboard compares every word's value and position. A fault in the slot walk shows up as a gap in the valid stream, or as a word that arrives when the queue is empty or is still missing when `busy` falls. The bench checks for all three.

// File: rtl/scale_desc_gen.sv
module scale_desc_gen #(
  parameter int DIM_W  = 12,
  parameter int KOFS_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DIM_W-1:0]  src_w,
  input  logic [DIM_W-1:0]  src_h,
  input  logic [DIM_W-1:0]  dst_w,
  input  logic [DIM_W-1:0]  dst_h,
  input  logic [31:0]       lb_base,
  input  logic [KOFS_W-1:0] kern_ofs,
  output logic              busy,
  output logic              err,
  output logic [10:0]       ctl_bits,
  output logic [DIM_W+4:0]  lb_size,
  output logic              out_valid,
  output logic [31:0]       out_word
);
  localparam int LB_W   = DIM_W + 5;
  localparam int NSLOT  = 14;
  localparam int SLOT_W = $clog2(NSLOT);
  localparam logic [1:0] M_NONE = 2'd0, M_TPZ = 2'd1, M_PPF = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_DIV, S_EMIT} st_t;
  st_t st;

  function automatic logic [1:0] mode_of(input logic [DIM_W-1:0] s, input logic [DIM_W-1:0] d);
    if (d > s) return M_PPF;
    else if (d < s) return M_TPZ;
    else return M_NONE;
  endfunction

  function automatic logic [2:0] code_of(input logic [1:0] h, input logic [1:0] v);
    case ({h, v})
      {M_PPF, M_PPF}:  return 3'd0;
      {M_TPZ, M_PPF}:  return 3'd1;
      {M_PPF, M_TPZ}:  return 3'd2;
      {M_TPZ, M_TPZ}:  return 3'd3;
      {M_PPF, M_NONE}: return 3'd4;
      {M_NONE, M_PPF}: return 3'd5;
      {M_NONE, M_TPZ}: return 3'd6;
      {M_TPZ, M_NONE}: return 3'd7;
      default:         return 3'd0;
    endcase
  endfunction

  logic [DIM_W-1:0]  sw_q, sh_q, dw_q, dh_q;
  logic [31:0]       base_q;
  logic [KOFS_W-1:0] kofs_q;
  logic [1:0]        hm_q, vm_q;
  logic [1:0]        d_idx;
  logic [4:0]        cnt;
  logic [32:0]       rem;
  logic [31:0]       quo, den;
  logic [31:0]       res [4];
  logic [SLOT_W-1:0] slot, nxt;
  logic              nxt_ok;

  wire       go       = start && (st == S_IDLE);
  wire       zero_dst = (dst_w == '0) || (dst_h == '0);
  wire [1:0] hm_n     = mode_of(src_w, dst_w);
  wire [1:0] vm_n     = mode_of(src_h, dst_h);
  wire       unity_n  = (hm_n == M_NONE) && (vm_n == M_NONE);
  wire [2:0] code_n   = unity_n ? 3'd0 : code_of(hm_n, vm_n);

  wire [DIM_W-1:0] mx     = (src_w > dst_w) ? src_w : dst_w;
  wire [LB_W-1:0]  lb_raw = (vm_n == M_TPZ) ? (LB_W'(mx) << 3) : (LB_W'(mx) << 4);
  wire [LB_W-1:0]  lb_rnd = (lb_raw + LB_W'(31)) & ~LB_W'(31);

  wire [32:0] rem_sh = {rem[31:0], quo[31]};
  wire        ge     = rem_sh >= {1'b0, den};
  wire [32:0] rem_n  = ge ? rem_sh - {1'b0, den} : rem_sh;
  wire [31:0] quo_n  = {quo[30:0], ge};

  logic [31:0] num_sel, den_sel;
  always_comb begin
    case (d_idx)
      2'd0:    begin num_sel = 32'(sw_q) << 16; den_sel = 32'(dw_q); end
      2'd1:    begin num_sel = 32'(sh_q) << 16; den_sel = 32'(dh_q); end
      2'd2:    begin num_sel = '1;              den_sel = res[0];    end
      default: begin num_sel = '1;              den_sel = res[1];    end
    endcase
  end

  logic [NSLOT-1:0] en;
  wire any_ppf = (hm_q == M_PPF) || (vm_q == M_PPF);
  assign en = {{4{any_ppf}}, {3{vm_q == M_TPZ}}, {2{hm_q == M_TPZ}},
               {2{vm_q == M_PPF}}, hm_q == M_PPF, vm_q != M_NONE, 1'b1};

  always_comb begin
    nxt_ok = 1'b0;
    nxt    = slot;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (en[i] && (i > int'(slot))) begin
        nxt_ok = 1'b1;
        nxt    = SLOT_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      err      <= 1'b0;
      ctl_bits <= '0;
      lb_size  <= '0;
      sw_q <= '0; sh_q <= '0; dw_q <= '0; dh_q <= '0;
      base_q <= '0; kofs_q <= '0; hm_q <= M_NONE; vm_q <= M_NONE;
      d_idx <= '0; cnt <= '0; rem <= '0; quo <= '0; den <= '0;
      slot <= '0;
      for (int i = 0; i < 4; i++) res[i] <= '0;
    end else begin
      case (st)
        S_IDLE: if (go) begin
          if (zero_dst) begin
            err      <= 1'b1;
            ctl_bits <= '0;
            lb_size  <= '0;
          end else begin
            err      <= 1'b0;
            ctl_bits <= {code_n, code_n, unity_n, 4'b0};
            lb_size  <= unity_n ? '0 : lb_rnd;
            sw_q <= src_w; sh_q <= src_h; dw_q <= dst_w; dh_q <= dst_h;
            base_q <= lb_base; kofs_q <= kern_ofs;
            hm_q <= hm_n; vm_q <= vm_n;
            d_idx <= '0;
            if (!unity_n) st <= S_LOAD;
          end
        end
        S_LOAD: begin
          quo <= num_sel;
          den <= den_sel;
          rem <= '0;
          cnt <= '0;
          st  <= S_DIV;
        end
        S_DIV: begin
          rem <= rem_n;
          quo <= quo_n;
          cnt <= cnt + 5'd1;
          if (cnt == 5'd31) begin
            res[d_idx] <= quo_n;
            if (d_idx == 2'd3) begin
              st   <= S_EMIT;
              slot <= '0;
            end else begin
              d_idx <= d_idx + 2'd1;
              st    <= S_LOAD;
            end
          end
        end
        default: begin
          if (nxt_ok) slot <= nxt;
          else st <= S_IDLE;
        end
      endcase
    end
  end

  assign busy      = (st != S_IDLE);
  assign out_valid = (st == S_EMIT);

  always_comb begin
    case (slot)
      SLOT_W'(0):  out_word = {4'b0, 12'(dh_q), 4'b0, 12'(dw_q)};
      SLOT_W'(1):  out_word = base_q;
      SLOT_W'(2):  out_word = {7'b0100000, res[0][16:0], 8'b0};
      SLOT_W'(3):  out_word = {7'b0100000, res[1][16:0], 8'b0};
      SLOT_W'(5):  out_word = {3'b0, res[0][20:0], 8'b0};
      SLOT_W'(6):  out_word = {16'b0, res[2][15:0]};
      SLOT_W'(7):  out_word = {3'b0, res[1][20:0], 8'b0};
      SLOT_W'(8):  out_word = {16'b0, res[3][15:0]};
      SLOT_W'(4),
      SLOT_W'(9):  out_word = 32'hC0C0_C0C0;
      default:     out_word = 32'(kofs_q);
    endcase
  end
endmodule

// File: rtl/scale_desc_gen_chk.sv
module scale_desc_gen_chk #(
  parameter int DIM_W  = 12,
  parameter int KOFS_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [DIM_W-1:0]  dst_w,
  input logic [DIM_W-1:0]  dst_h,
  input logic              busy,
  input logic              err,
  input logic [10:0]       ctl_bits,
  input logic [DIM_W+4:0]  lb_size,
  input logic              out_valid
);
  AST_CODE_TWICE: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_bits[10:8] == ctl_bits[7:5]); // R1
  AST_UNITY_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_bits[4] |-> (ctl_bits[10:5] == 6'd0 && !busy)); // R2
  AST_LB_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    lb_size[4:0] == 5'd0); // R9
  AST_LB_UNITY: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_bits[4] |-> lb_size == '0); // R9
  AST_VALID_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> busy); // R10
  AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(out_valid)); // R10
  AST_ZERO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (dst_w == '0 || dst_h == '0)) |=> (err && !busy)); // R11
  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy); // R11
  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(ctl_bits) && $stable(lb_size) && !err); // R12
endmodule

bind scale_desc_gen scale_desc_gen_chk #(.DIM_W(DIM_W), .KOFS_W(KOFS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .dst_w(dst_w), .dst_h(dst_h),
  .busy(busy), .err(err), .ctl_bits(ctl_bits), .lb_size(lb_size), .out_valid(out_valid));

// File: tb/sim_scale_desc_gen.sv
module sim_scale_desc_gen;
  localparam int DIM_W = 12, KOFS_W = 14;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [DIM_W-1:0] src_w = '0, src_h = '0, dst_w = '0, dst_h = '0;
  logic [31:0] lb_base = '0;
  logic [KOFS_W-1:0] kern_ofs = '0;
  logic busy, err, out_valid;
  logic [10:0] ctl_bits;
  logic [DIM_W+4:0] lb_size;
  logic [31:0] out_word;

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  bit in_burst = 0;

  always #2 clk = ~clk;

  scale_desc_gen #(.DIM_W(DIM_W), .KOFS_W(KOFS_W)) u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        in_burst = 1;
        if (exp_q.size() == 0) chk(0, "R10 unexpected word", out_word, 32'hx);
        else begin
          automatic logic [31:0] e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          chk(out_word === e, t, out_word, e);
        end
      end else if (in_burst && busy) begin
        chk(0, "R10 gap in word stream", 0, 1);
        in_burst = 0;
      end
      if (!busy) in_burst = 0;
    end
  end

  function automatic logic [1:0] md(input int s, input int d);
    return (d > s) ? 2'd2 : (d < s) ? 2'd1 : 2'd0;
  endfunction

  task automatic push(input logic [31:0] w, input string t);
    exp_q.push_back(w);
    tag_q.push_back(t);
  endtask

  task automatic run(input int sw, input int sh, input int dw, input int dh,
                     input logic [31:0] base, input int ko, input bit poke);
    automatic logic [1:0] h = md(sw, dw), v = md(sh, dh);
    automatic bit uni = (h == 0 && v == 0);
    automatic logic [2:0] code;
    automatic logic [31:0] sch = 0, scv = 0;
    automatic int mx = (sw > dw) ? sw : dw;
    automatic int lb;
    case ({h, v})
      4'b1010: code = 0; 4'b0110: code = 1; 4'b1001: code = 2; 4'b0101: code = 3;
      4'b1000: code = 4; 4'b0010: code = 5; 4'b0001: code = 6; 4'b0100: code = 7;
      default: code = 0;
    endcase
    lb = uni ? 0 : (((v == 1 ? mx * 8 : mx * 16) + 31) / 32) * 32;
    if (!uni) begin
      sch = (32'(sw) << 16) / 32'(dw);
      scv = (32'(sh) << 16) / 32'(dh);
      push({4'b0, 12'(dh), 4'b0, 12'(dw)}, "R3 size word");
      if (v != 0) push(base, "R4 base word");
      if (h == 2) push(32'h4000_0000 | ((sch & 32'h1FFFF) << 8), "R5 H-PPF word");
      if (v == 2) begin
        push(32'h4000_0000 | ((scv & 32'h1FFFF) << 8), "R5 V-PPF word");
        push(32'hC0C0C0C0, "R7 V-PPF context");
      end
      if (h == 1) begin
        push((sch & 32'h1FFFFF) << 8, "R6 H-TPZ scale");
        push((32'hFFFFFFFF / sch) & 32'hFFFF, "R6 H-TPZ recip");
      end
      if (v == 1) begin
        push((scv & 32'h1FFFFF) << 8, "R6 V-TPZ scale");
        push((32'hFFFFFFFF / scv) & 32'hFFFF, "R6 V-TPZ recip");
        push(32'hC0C0C0C0, "R7 V-TPZ context");
      end
      if (h == 2 || v == 2) for (int k = 0; k < 4; k++) push(32'(ko) & 32'h3FFF, "R8 kernel ptr");
    end
    @(negedge clk);
    src_w = DIM_W'(sw); src_h = DIM_W'(sh); dst_w = DIM_W'(dw); dst_h = DIM_W'(dh);
    lb_base = base; kern_ofs = KOFS_W'(ko); start = 1;
    @(negedge clk);
    start = 0;
    chk(ctl_bits === {code, code, uni, 4'b0}, "R1 R2 ctl_bits", 32'(ctl_bits), {21'b0, code, code, uni, 4'b0});
    chk(lb_size === (DIM_W+5)'(lb), "R9 lb_size", 32'(lb_size), 32'(lb));
    chk(err === 1'b0, "R11 err clear", 32'(err), 0);
    chk(busy === !uni, "R2 R10 busy after start", 32'(busy), 32'(!uni));
    if (poke) begin
      repeat (20) @(negedge clk);
      dst_w = 0; src_w = 1; start = 1;
      @(negedge clk);
      start = 0;
      chk(err === 1'b0, "R12 err untouched", 32'(err), 0);
      chk(ctl_bits === {code, code, uni, 4'b0}, "R12 ctl untouched", 32'(ctl_bits), {21'b0, code, code, uni, 4'b0});
    end
    while (busy) @(negedge clk);
    @(negedge clk);
    chk(exp_q.size() == 0, "R10 all words emitted before busy fell", exp_q.size(), 0);
    exp_q.delete(); tag_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "R10 watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy === 0 && out_valid === 0 && err === 0, "R10 reset idle", {busy, out_valid, err}, 0);
    chk(ctl_bits === 0 && lb_size === 0, "R9 reset fields", 32'(ctl_bits) | 32'(lb_size), 0);
    rst_n = 1;
    @(negedge clk);
    run(10, 10, 10, 10, 32'h1234, 5, 0);          // R2 unity
    chk(out_valid === 0, "R2 unity emits nothing", 32'(out_valid), 0);
    run(100, 50, 200, 100, 32'h0000_4000, 77, 0); // PPF/PPF
    run(640, 480, 320, 240, 32'h0000_8020, 9, 0); // TPZ/TPZ
    run(640, 100, 320, 300, 32'hABCD_0000, 3, 0); // TPZ/PPF
    run(100, 480, 300, 240, 32'h0000_0100, 12, 0);// PPF/TPZ
    run(100, 60, 150, 60, 32'hDEAD_BEEF, 4095, 0);// PPF/none
    run(80, 60, 80, 61, 32'h0000_0040, 16383, 0); // none/PPF
    run(80, 60, 80, 30, 32'h0000_0800, 1, 0);     // none/TPZ
    run(4095, 60, 1, 60, 32'h0000_0000, 2, 0);    // TPZ/none, extreme ratio
    run(7, 4095, 4095, 4095, 32'h5555_AAAA, 0, 0);// PPF/none, large lb
    // R11 zero destination
    @(negedge clk);
    src_w = 10; src_h = 10; dst_w = 10; dst_h = 0; start = 1;
    @(negedge clk);
    start = 0;
    chk(err === 1'b1, "R11 err on zero dst", 32'(err), 1);
    chk(ctl_bits === 0 && lb_size === 0 && busy === 0, "R11 fields cleared", 32'(ctl_bits) | 32'(lb_size), 0);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0 && out_valid === 0, "R11 no words", 32'(out_valid), 0);
    run(64, 64, 32, 64, 32'h0000_0200, 8, 1);     // R12 poke while busy; clears R11 err
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule